// File: doc/BRIEF.md
# Speculative Oldest-First Issue Window

This block is an issue window that keeps up to DEPTH in-flight operations in program order, in a ring between a head and a tail pointer. Each operation carries two source tags, and each tag has its own ready bit. When a result tag is broadcast, every waiting source with that tag becomes ready. An operation asks to issue once both of its sources are ready and it has not issued yet.

Selection is oldest-first. The search starts at the head and moves toward the tail. A short selector looks only at the GROUP oldest slots and grants in the same cycle. A full-window scan runs alongside it and checks each of its choices. Sometimes no request sits in the head group, but the full scan finds one further back. In that case the block raises a miss pulse and issues nothing. On the next cycle it issues the entry the full scan found, and marks that grant as late.

Issued entries leave from the head in order, one per cycle.

Top module: `spec_issue_window`

## Requirements
- R1: While an entry is held, a broadcast with wk_valid high sets the ready bit of every source whose tag equals wk_tag. A source whose tag differs keeps its ready bit unchanged.
- R2: An entry requests issue only when both of its source ready bits are set.
- R3: The granted entry is the requesting entry nearest the head, counted in ring order from head_ptr. iss_idx is the absolute slot number.
- R4: If a request exists among the GROUP slots starting at the head, the grant appears in that same cycle, with iss_valid=1 and iss_late=0.
- R5: If no request lies in the head group but one lies further back, sel_miss=1 and iss_valid=0 in that cycle. In the next cycle the block grants that entry with iss_valid=1 and iss_late=1.
- R6: An entry that has been granted never requests again, so no slot is granted in two consecutive cycles.
- R7: When the head entry has issued, ret_valid=1. On the next cycle head_ptr has advanced by one, modulo DEPTH.
- R8: Suppose an entry is dispatched in the same cycle as a broadcast of one of its source tags. That source is stored as ready, even if the dispatch marks it not ready.
- R9: win_full=1 exactly when DEPTH entries are held. A dispatch presented while win_full=1 is dropped and does not overwrite any entry.
- R10: After reset the window is empty: head_ptr=0, and win_full, iss_valid, iss_late, sel_miss and ret_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch an operation at the tail |
| disp_src_a | input | TAG_W | First source tag |
| disp_rdy_a | input | 1 | First source already ready |
| disp_src_b | input | TAG_W | Second source tag |
| disp_rdy_b | input | 1 | Second source already ready |
| win_full | output | 1 | All DEPTH slots are held |
| wk_valid | input | 1 | Result tag broadcast valid |
| wk_tag | input | TAG_W | Broadcast result tag |
| iss_valid | output | 1 | An entry is granted this cycle |
| iss_idx | output | log2(DEPTH) | Slot of the granted entry |
| iss_late | output | 1 | Grant came from the full scan one cycle late |
| sel_miss | output | 1 | Head group held no request but the window did |
| ret_valid | output | 1 | Head entry retires this cycle |
| head_ptr | output | log2(DEPTH) | Slot of the oldest entry |

## Verification
The bench builds the window with DEPTH=8, GROUP=3 and TAG_W=4. At that size every one of the 255 non-empty request patterns over a full window can be swept.

Before each pattern, a varying number of filler operations rotates the head. This places the oldest request at every ring offset, both inside and beyond the head group, and makes the wrap of iss_idx and head_ptr part of almost every case.

A dispatch presented while the window is full is aimed at the head slot, so if it were accepted it would change the expected grant.

// File: rtl/iw_pkg.sv
package iw_pkg;

  // Which path supplies the grant in a given cycle
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_FAST = 2'd1,
    SEL_MISS = 2'd2,
    SEL_LATE = 2'd3
  } sel_kind_e;

endpackage

// File: rtl/iw_pick.sv
// Lowest-index set bit of a request vector (index 0 = oldest)
module iw_pick #(
  parameter int W     = 4,
  parameter int OFF_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic             hit,
  output logic [OFF_W-1:0] off
);

  always_comb begin
    hit = 1'b0;
    off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req[k]) begin
        hit = 1'b1;
        off = OFF_W'(k);
      end
    end
  end

endmodule

// File: rtl/iw_slots.sv
// Entry storage: tags, ready bits, wakeup, issue marking and release
module iw_slots #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 6,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [TAG_W-1:0] wr_tag_a,
  input  logic             wr_rdy_a,
  input  logic [TAG_W-1:0] wr_tag_b,
  input  logic             wr_rdy_b,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic             mark_en,
  input  logic [PTR_W-1:0] mark_ptr,
  input  logic             free_en,
  input  logic [PTR_W-1:0] free_ptr,
  output logic [DEPTH-1:0] slot_req,
  output logic [DEPTH-1:0] slot_done
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             vld_q, vld_d, isd_q, isd_d;
    logic             ra_q, ra_d, rb_q, rb_d;
    logic [TAG_W-1:0] ta_q, ta_d, tb_q, tb_d;
    logic             wr_here;

    assign wr_here = wr_en && (wr_ptr == PTR_W'(i));

    always_comb begin
      vld_d = vld_q;
      isd_d = isd_q;
      ra_d  = ra_q;
      rb_d  = rb_q;
      ta_d  = ta_q;
      tb_d  = tb_q;
      if (vld_q && wk_valid) begin
        if (ta_q == wk_tag) ra_d = 1'b1;
        if (tb_q == wk_tag) rb_d = 1'b1;
      end
      if (mark_en && (mark_ptr == PTR_W'(i))) isd_d = 1'b1;
      if (free_en && (free_ptr == PTR_W'(i))) begin
        vld_d = 1'b0;
        isd_d = 1'b0;
      end
      if (wr_here) begin
        vld_d = 1'b1;
        isd_d = 1'b0;
        ta_d  = wr_tag_a;
        tb_d  = wr_tag_b;
        ra_d  = wr_rdy_a || (wk_valid && (wr_tag_a == wk_tag));
        rb_d  = wr_rdy_b || (wk_valid && (wr_tag_b == wk_tag));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        isd_q <= 1'b0;
        ra_q  <= 1'b0;
        rb_q  <= 1'b0;
        ta_q  <= '0;
        tb_q  <= '0;
      end else begin
        vld_q <= vld_d;
        isd_q <= isd_d;
        ra_q  <= ra_d;
        rb_q  <= rb_d;
        ta_q  <= ta_d;
        tb_q  <= tb_d;
      end
    end

    assign slot_req[i]  = vld_q && !isd_q && ra_q && rb_q;
    assign slot_done[i] = vld_q && isd_q;
  end

endmodule

// File: rtl/spec_issue_window.sv
module spec_issue_window
  import iw_pkg::*;
#(
  parameter int  DEPTH  = 16,
  parameter int  GROUP  = 4,
  parameter int  TAG_W  = 6,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int GOFF_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [TAG_W-1:0] disp_src_a,
  input  logic             disp_rdy_a,
  input  logic [TAG_W-1:0] disp_src_b,
  input  logic             disp_rdy_b,
  output logic             win_full,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  output logic             iss_valid,
  output logic [PTR_W-1:0] iss_idx,
  output logic             iss_late,
  output logic             sel_miss,
  output logic             ret_valid,
  output logic [PTR_W-1:0] head_ptr
);

  localparam logic [PTR_W:0] FULL_CNT = (PTR_W + 1)'(DEPTH);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [PTR_W:0]   cnt_q, cnt_d;
  logic             late_q, late_d;
  logic [PTR_W-1:0] late_idx_q, late_idx_d;
  logic             disp_acc;
  logic [DEPTH-1:0] slot_req, slot_done, age_req;
  logic             fast_hit, full_hit;
  logic [GOFF_W-1:0] fast_off;
  logic [PTR_W-1:0] full_off;
  sel_kind_e        sel_kind;

  assign win_full  = (cnt_q == FULL_CNT);
  assign disp_acc  = disp_valid && !win_full;
  assign ret_valid = slot_done[head_q];
  assign head_ptr  = head_q;

  // Re-order requests by age: bit k is the k-th oldest slot
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_req[k] = slot_req[PTR_W'(head_q + PTR_W'(k))];
  end

  iw_pick #(.W(GROUP), .OFF_W(GOFF_W)) u_fast (
    .req (age_req[GROUP-1:0]),
    .hit (fast_hit),
    .off (fast_off)
  );

  iw_pick #(.W(DEPTH), .OFF_W(PTR_W)) u_full (
    .req (age_req),
    .hit (full_hit),
    .off (full_off)
  );

  always_comb begin
    if (late_q)        sel_kind = SEL_LATE;
    else if (fast_hit) sel_kind = SEL_FAST;
    else if (full_hit) sel_kind = SEL_MISS;
    else               sel_kind = SEL_IDLE;
  end

  always_comb begin
    iss_valid = 1'b0;
    iss_late  = 1'b0;
    sel_miss  = 1'b0;
    iss_idx   = '0;
    unique case (sel_kind)
      SEL_LATE: begin
        iss_valid = 1'b1;
        iss_late  = 1'b1;
        iss_idx   = late_idx_q;
      end
      SEL_FAST: begin
        iss_valid = 1'b1;
        iss_idx   = PTR_W'(head_q + PTR_W'(fast_off));
      end
      SEL_MISS: sel_miss = 1'b1;
      default:  ;
    endcase
  end

  // Next-state of pointers, occupancy and the late-grant stage
  always_comb begin
    head_d     = head_q;
    tail_d     = tail_q;
    cnt_d      = cnt_q;
    late_d     = sel_miss;
    late_idx_d = late_idx_q;
    if (sel_miss) late_idx_d = PTR_W'(head_q + full_off);
    if (ret_valid) head_d = PTR_W'(head_q + 1'b1);
    if (disp_acc)  tail_d = PTR_W'(tail_q + 1'b1);
    cnt_d = cnt_q + (PTR_W + 1)'(disp_acc) - (PTR_W + 1)'(ret_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      cnt_q      <= '0;
      late_q     <= 1'b0;
      late_idx_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      late_q <= late_d;
      if (sel_miss) late_idx_q <= late_idx_d;
    end
  end

  iw_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PTR_W(PTR_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (disp_acc),
    .wr_ptr    (tail_q),
    .wr_tag_a  (disp_src_a),
    .wr_rdy_a  (disp_rdy_a),
    .wr_tag_b  (disp_src_b),
    .wr_rdy_b  (disp_rdy_b),
    .wk_valid  (wk_valid),
    .wk_tag    (wk_tag),
    .mark_en   (iss_valid),
    .mark_ptr  (iss_idx),
    .free_en   (ret_valid),
    .free_ptr  (head_q),
    .slot_req  (slot_req),
    .slot_done (slot_done)
  );

endmodule

// File: rtl/iw_checker.sv
module iw_checker #(
  parameter int  DEPTH  = 16,
  parameter int  GROUP  = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int GOFF_W = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [PTR_W-1:0]  iss_idx,
  input logic              iss_late,
  input logic              sel_miss,
  input logic              ret_valid,
  input logic [PTR_W-1:0]  head_ptr,
  input logic              win_full,
  input logic              fast_hit,
  input logic              full_hit,
  input logic [GOFF_W-1:0] fast_off,
  input logic [PTR_W-1:0]  full_off
);

  // R3
  fast_agrees_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_hit |-> (full_hit && (PTR_W'(fast_off) == full_off)));

  // R5
  miss_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_miss |-> !iss_valid);

  // R5
  miss_then_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_miss |=> (iss_valid && iss_late));

  // R5
  late_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_late |-> $past(sel_miss));

  // R6
  no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !(iss_valid && (iss_idx == $past(iss_idx))));

  // R7
  retire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (head_ptr == PTR_W'($past(head_ptr) + 1'b1)));

  // R9
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full && !ret_valid) |=> win_full);

endmodule

bind spec_issue_window iw_checker #(.DEPTH(DEPTH), .GROUP(GROUP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_idx   (iss_idx),
  .iss_late  (iss_late),
  .sel_miss  (sel_miss),
  .ret_valid (ret_valid),
  .head_ptr  (head_ptr),
  .win_full  (win_full),
  .fast_hit  (fast_hit),
  .full_hit  (full_hit),
  .fast_off  (fast_off),
  .full_off  (full_off)
);

// File: tb/spec_issue_window_test.sv
module spec_issue_window_test;

  localparam int D  = 8;
  localparam int G  = 3;
  localparam int T  = 4;
  localparam int PW = $clog2(D);

  logic          clk;
  logic          rst_n;
  logic          disp_valid;
  logic [T-1:0]  disp_src_a, disp_src_b;
  logic          disp_rdy_a, disp_rdy_b;
  logic          win_full;
  logic          wk_valid;
  logic [T-1:0]  wk_tag;
  logic          iss_valid, iss_late, sel_miss, ret_valid;
  logic [PW-1:0] iss_idx, head_ptr;

  int tests = 0;
  int fails = 0;
  int hexp  = 0;

  spec_issue_window #(.DEPTH(D), .GROUP(G), .TAG_W(T)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_valid (disp_valid),
    .disp_src_a (disp_src_a),
    .disp_rdy_a (disp_rdy_a),
    .disp_src_b (disp_src_b),
    .disp_rdy_b (disp_rdy_b),
    .win_full   (win_full),
    .wk_valid   (wk_valid),
    .wk_tag     (wk_tag),
    .iss_valid  (iss_valid),
    .iss_idx    (iss_idx),
    .iss_late   (iss_late),
    .sel_miss   (sel_miss),
    .ret_valid  (ret_valid),
    .head_ptr   (head_ptr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #2;
  endtask

  task automatic disp(input int ta, input bit ra, input int tb, input bit rb);
    disp_valid = 1'b1;
    disp_src_a = T'(ta);
    disp_rdy_a = ra;
    disp_src_b = T'(tb);
    disp_rdy_b = rb;
    cyc();
    disp_valid = 1'b0;
  endtask

  task automatic wake(input int tg);
    wk_valid = 1'b1;
    wk_tag   = T'(tg);
    cyc();
    wk_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    disp_valid = 1'b0;
    disp_src_a = '0;
    disp_src_b = '0;
    disp_rdy_a = 1'b0;
    disp_rdy_b = 1'b0;
    wk_valid = 1'b0;
    wk_tag = '0;
    repeat (3) cyc();
    // R10 reset state
    chk(!iss_valid, "R10 iss_valid", int'(iss_valid), 0);
    chk(!iss_late && !sel_miss, "R10 late/miss", int'({iss_late, sel_miss}), 0);
    chk(!ret_valid, "R10 ret_valid", int'(ret_valid), 0);
    chk(!win_full, "R10 win_full", int'(win_full), 0);
    chk(head_ptr == 0, "R10 head_ptr", int'(head_ptr), 0);
    rst_n = 1'b1;
    cyc();

    // R8: dispatch and broadcast of the same tag in one cycle
    disp_valid = 1'b1;
    disp_src_a = T'(5);
    disp_rdy_a = 1'b0;
    disp_src_b = T'(0);
    disp_rdy_b = 1'b1;
    wk_valid   = 1'b1;
    wk_tag     = T'(5);
    cyc();
    disp_valid = 1'b0;
    wk_valid   = 1'b0;
    chk(iss_valid && !iss_late, "R8 same-cycle wake issues", int'(iss_valid), 1);
    chk(int'(iss_idx) == hexp, "R8 issue slot", int'(iss_idx), hexp);
    cyc();
    chk(!iss_valid, "R6 no second grant", int'(iss_valid), 0);
    chk(ret_valid && int'(head_ptr) == hexp, "R7 retire at head", int'(ret_valid), 1);
    cyc();
    hexp = (hexp + 1) % D;
    chk(int'(head_ptr) == hexp, "R7 head advanced", int'(head_ptr), hexp);
    chk(!ret_valid, "R7 single retire", int'(ret_valid), 0);

    // R1/R2: only the matching tag wakes a source
    disp(6, 1'b0, 0, 1'b1);
    chk(!iss_valid, "R2 waiting entry idle", int'(iss_valid), 0);
    wake(7);
    chk(!iss_valid, "R1 non-matching tag", int'(iss_valid), 0);
    wake(6);
    chk(iss_valid && int'(iss_idx) == hexp, "R1 matching tag wakes", int'(iss_idx), hexp);
    repeat (4) cyc();
    hexp = (hexp + 1) % D;
    chk(int'(head_ptr) == hexp, "R7 head after drain", int'(head_ptr), hexp);

    // Sweep every non-empty request pattern over a full window
    for (int p = 1; p < (1 << D); p++) begin
      int s;
      int f;
      int want;
      s = p % D;
      for (int j = 0; j < s; j++) disp(0, 1'b1, 0, 1'b1);
      repeat (30) cyc();
      hexp = (hexp + s) % D;
      chk(int'(head_ptr) == hexp, "R7 head after fillers", int'(head_ptr), hexp);
      // tag 1 holds every entry; tag 3 holds entries outside the pattern
      for (int k = 0; k < D; k++) begin
        if (p[k]) disp(1, 1'b0, 2, 1'b1);
        else      disp(1, 1'b0, 3, 1'b0);
      end
      chk(win_full, "R9 full after DEPTH dispatches", int'(win_full), 1);
      chk(!iss_valid && !sel_miss, "R2 nothing ready yet", int'(iss_valid), 0);
      disp(2, 1'b1, 2, 1'b1);  // must be dropped: would land on head slot
      wake(1);
      f = 0;
      for (int k = D - 1; k >= 0; k--) if (p[k]) f = k;
      want = (hexp + f) % D;
      if (f < G) begin
        chk(iss_valid && !iss_late && !sel_miss, "R4 in-group grant",
            int'({iss_valid, iss_late, sel_miss}), 4);
        chk(int'(iss_idx) == want, "R3 oldest grant (R9 drop)", int'(iss_idx), want);
      end else begin
        chk(sel_miss && !iss_valid, "R5 miss pulse", int'({sel_miss, iss_valid}), 2);
        cyc();
        chk(iss_valid && iss_late, "R5 late grant", int'({iss_valid, iss_late}), 3);
        chk(int'(iss_idx) == want, "R3 late oldest grant (R9 drop)", int'(iss_idx), want);
      end
      wake(3);
      repeat (40) cyc();
      chk(!win_full && !iss_valid && !ret_valid, "R7 window drained",
          int'({win_full, iss_valid, ret_valid}), 0);
      chk(int'(head_ptr) == hexp, "R7 head after drain", int'(head_ptr), hexp);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule